// File: doc/BRIEF.md
# Auxiliary Clock Output Generator

This block derives two auxiliary clock pins from the main oscillator clock. The slow output divides the oscillator by one of four ratios: 6, 10, 12, or a fractional 7.5. These ratios are chosen so that a 1.8432 MHz serial-port reference clock can be obtained from any of the common crystals: 11.0592, 18.432, 22.1184 or 13.824 MHz. The fast output carries either the oscillator itself or the oscillator divided by two.

Each output has its own enable input. A disabled output is held at logic 0. Control inputs are level signals from a control register in the oscillator domain. The block does not apply a control change the moment it arrives. It holds the change back until a point where the affected output is low, so that switching ratios or enables never produces a shortened pulse.

Top module: `auxclk_gen`

## Requirements
- R1: `out2_ratio` selects the slow-output ratio with this encoding: 2'b00 gives 7.5, 2'b01 gives 6, 2'b10 gives 12, and 2'b11 gives 10. With the even ratios, the slow output has a period of exactly 6, 12 or 10 oscillator cycles.
- R2: At ratio 7.5, the slow output alternates between an 8-cycle period and a 7-cycle period, so its rising edges repeat every 15 oscillator cycles.
- R3: The high phase of the slow output lasts half the period at the even ratios, and 4 cycles in both periods of the 7.5 ratio. The duty cycle therefore stays within half an oscillator cycle of 50%.
- R4: While the applied slow-output enable is 0, `out2_clk` stays at 0.
- R5: While the applied fast-output enable is 0, `out1_clk` stays at 0.
- R6: With `out1_fast` = 1, `out1_clk` follows the oscillator: it is 1 while `clk` is high and 0 while `clk` is low. With `out1_fast` = 0, it is the oscillator divided by two, each level lasting one full oscillator cycle.
- R7: A change of `out2_ratio` or `out2_en` is applied only at the end of the current slow-output period, which always ends in a low phase. As a result, every high phase and every low phase lasts at least 3 oscillator cycles.
- R8: A change of `out1_en` or `out1_fast` is applied only on a falling oscillator edge at which the divide-by-two phase is low. A change made while the divided output is high therefore first completes that full high level and the following low level.
- R9: Synchronous active-high `rst` clears both applied enables, the ratio selection and the divide-by-two phase. Both outputs are 0 during reset and stay 0 afterwards until they are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| out1_en | input | 1 | Fast output enable |
| out1_fast | input | 1 | 1: pass the oscillator through; 0: divide it by two |
| out2_en | input | 1 | Slow output enable |
| out2_ratio | input | 2 | Slow output ratio select (encoding in R1) |
| out1_clk | output | 1 | Fast auxiliary clock |
| out2_clk | output | 1 | Slow auxiliary clock |

## Verification
The assertions assume that the control inputs change only in the oscillator domain, away from the rising edge, as if written by a register clocked by `clk`. The bench honours this by driving every control change one nanosecond after a rising edge. The assertions also assume that reset is held for at least one full cycle, covering both clock edges. The bench holds reset for several cycles from time zero, so the falling-edge control stage is cleared as well.

// File: rtl/auxclk_pkg.sv
package auxclk_pkg;

    localparam int unsigned CNT_W = 4;

    typedef enum logic [1:0] {
        SEL_DIV7P5 = 2'b00,
        SEL_DIV6   = 2'b01,
        SEL_DIV12  = 2'b10,
        SEL_DIV10  = 2'b11
    } ratio_e;

    typedef struct packed {
        logic   en;
        ratio_e ratio;
    } slow_cfg_t;

    typedef struct packed {
        logic en;
        logic fast;
    } fast_cfg_t;

    // Length of one output period in oscillator cycles; the 7.5 ratio alternates 8 and 7.
    function automatic logic [CNT_W-1:0] period_len(input ratio_e r, input logic alt);
        case (r)
            SEL_DIV7P5: period_len = alt ? CNT_W'(7) : CNT_W'(8);
            SEL_DIV6:   period_len = CNT_W'(6);
            SEL_DIV12:  period_len = CNT_W'(12);
            default:    period_len = CNT_W'(10);
        endcase
    endfunction

    // Number of high cycles at the start of each period.
    function automatic logic [CNT_W-1:0] high_len(input ratio_e r);
        case (r)
            SEL_DIV7P5: high_len = CNT_W'(4);
            SEL_DIV6:   high_len = CNT_W'(3);
            SEL_DIV12:  high_len = CNT_W'(6);
            default:    high_len = CNT_W'(5);
        endcase
    endfunction

endpackage

// File: rtl/auxclk_slow_div.sv
module auxclk_slow_div
    import auxclk_pkg::*;
#(
    parameter int unsigned W = auxclk_pkg::CNT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  slow_cfg_t cfg_in,
    output logic      clk_out
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_d;
    slow_cfg_t    cfg_q, cfg_d;
    logic         alt_q, alt_d;
    logic         out_q, out_d;
    logic         wrap;

    assign wrap = (cnt_q == period_len(cfg_q.ratio, alt_q) - ONE);

    always_comb begin
        if (wrap) begin
            cnt_d = '0;
            cfg_d = cfg_in;
            alt_d = (cfg_q.ratio == SEL_DIV7P5) && (cfg_in.ratio == SEL_DIV7P5) && !alt_q;
        end else begin
            cnt_d = cnt_q + ONE;
            cfg_d = cfg_q;
            alt_d = alt_q;
        end
        out_d = cfg_d.en && (cnt_d < high_len(cfg_d.ratio));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cfg_q <= '0;
            alt_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            cfg_q <= cfg_d;
            alt_q <= alt_d;
            out_q <= out_d;
        end
    end

    assign clk_out = out_q;

    // R7: applied configuration only moves after a low cycle
    assert_cfg_at_low_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> !$past(out_q));

    // R7: a high phase starts only at the beginning of a period
    assert_rise_at_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> (cnt_q == '0));

    // R2: counter stays inside the current period
    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < period_len(cfg_q.ratio, alt_q));

    // R9: output is low on the cycle after reset is seen
    assert_reset_low_R9: assert property (@(posedge clk)
        $past(rst) |-> !out_q);

endmodule

// File: rtl/auxclk_fast_div.sv
module auxclk_fast_div
    import auxclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fast_cfg_t cfg_in,
    output logic      clk_out
);

    logic      half_q;
    fast_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= !half_q;
    end

    // Settings are taken on a falling edge while both candidate outputs are low.
    always_ff @(negedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (!half_q) cfg_q <= cfg_in;
    end

    assign clk_out = cfg_q.en & (cfg_q.fast ? clk : half_q);

    // R6: the divided phase toggles on every rising edge outside reset
    assert_half_toggles_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (half_q != $past(half_q)));

    // R8: applied setting changes only when the divided phase was low
    assert_cfg_when_low_R8: assert property (@(negedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> !$past(half_q));

endmodule

// File: rtl/auxclk_gen.sv
module auxclk_gen
    import auxclk_pkg::*;
#(
    parameter int unsigned CNT_W = auxclk_pkg::CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       out1_en,
    input  logic       out1_fast,
    input  logic       out2_en,
    input  logic [1:0] out2_ratio,
    output logic       out1_clk,
    output logic       out2_clk
);

    slow_cfg_t slow_req;
    fast_cfg_t fast_req;

    assign slow_req.en    = out2_en;
    assign slow_req.ratio = ratio_e'(out2_ratio);
    assign fast_req.en    = out1_en;
    assign fast_req.fast  = out1_fast;

    auxclk_slow_div #(.W(CNT_W)) slow_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_in  (slow_req),
        .clk_out (out2_clk)
    );

    auxclk_fast_div fast_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_in  (fast_req),
        .clk_out (out1_clk)
    );

endmodule

// File: tb/auxclk_gen_tb.sv
`timescale 1ns/1ps
module auxclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       out1_en = 1'b0;
    logic       out1_fast = 1'b0;
    logic       out2_en = 1'b0;
    logic [1:0] out2_ratio = 2'b00;
    logic       out1_clk;
    logic       out2_clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic smp [0:255];

    always #2 clk = ~clk;

    auxclk_gen dut_i (
        .clk(clk), .rst(rst), .out1_en(out1_en), .out1_fast(out1_fast),
        .out2_en(out2_en), .out2_ratio(out2_ratio),
        .out1_clk(out1_clk), .out2_clk(out2_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic capture2(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            smp[i] = out2_clk;
        end
    endtask

    task automatic test_reset();
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk(out1_clk == 0 && out2_clk == 0, "R9 outputs low in reset", {out1_clk, out2_clk}, 0);
        end
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            chk(out1_clk == 0 && out2_clk == 0, "R9 outputs low after reset", {out1_clk, out2_clk}, 0);
            #2;
            chk(out1_clk == 0, "R9 fast output low half", out1_clk, 0);
        end
    endtask

    task automatic test_ratio(input logic [1:0] sel, input int per_a, input int per_b, input int hi);
        int rs [0:63];
        int nr = 0;
        out2_ratio = sel;
        out2_en = 1'b1;
        cycles(30);
        capture2(100);
        for (int i = 1; i < 100; i++)
            if (smp[i] && !smp[i-1]) begin rs[nr] = i; nr++; end
        chk(nr >= 6, "R1 enough periods", nr, 6);
        for (int k = 0; k + 1 < nr; k++) begin
            int d = rs[k+1] - rs[k];
            int h = 0;
            for (int j = rs[k]; j < rs[k+1] && smp[j]; j++) h++;
            if (per_a == per_b) begin
                chk(d == per_a, "R1 period length", d, per_a);
                chk(h == hi, "R3 high phase length", h, hi);
            end else begin
                chk(d == per_a || d == per_b, "R2 period is 7 or 8", d, per_a);
                chk(h == hi, "R3 high phase at 7.5", h, hi);
                if (k + 2 < nr)
                    chk(rs[k+2] - rs[k] == per_a + per_b, "R2 15-cycle repeat", rs[k+2] - rs[k], 15);
            end
        end
    endtask

    task automatic test_slow_disable();
        out2_en = 1'b0;
        cycles(14);
        capture2(40);
        for (int i = 0; i < 40; i++)
            chk(smp[i] == 0, "R4 disabled slow output low", smp[i], 0);
    endtask

    task automatic test_slow_switching();
        int run = 0;
        int first = 1;
        out2_en = 1'b1;
        fork
            capture2(200);
            begin
                for (int s = 0; s < 24; s++) begin
                    repeat (3 + (s % 5)) @(posedge clk);
                    #1;
                    out2_ratio = 2'(s * 3 + 1);
                    if (s % 7 == 6) out2_en = ~out2_en;
                end
            end
        join
        for (int i = 1; i < 200; i++) begin
            if (smp[i] != smp[i-1]) begin
                if (!first)
                    chk(run >= 3, "R7 no runt phase", run, 3);
                first = 0;
                run = 1;
            end else begin
                run++;
            end
        end
    endtask

    task automatic test_fast_modes();
        out1_en = 1'b1;
        out1_fast = 1'b1;
        cycles(4);
        for (int i = 0; i < 8; i++) begin
            chk(out1_clk == 1, "R6 pass-through high half", out1_clk, 1);
            #2;
            chk(out1_clk == 0, "R6 pass-through low half", out1_clk, 0);
            @(posedge clk); #1;
        end
        out1_fast = 1'b0;
        cycles(4);
        begin
            logic prev = out1_clk;
            for (int i = 0; i < 10; i++) begin
                #2;
                chk(out1_clk == prev, "R6 divide-by-two level holds", out1_clk, prev);
                @(posedge clk); #1;
                chk(out1_clk == !prev, "R6 divide-by-two toggles", out1_clk, !prev);
                prev = out1_clk;
            end
        end
        out1_en = 1'b0;
        cycles(4);
        for (int i = 0; i < 8; i++) begin
            chk(out1_clk == 0, "R5 disabled fast output high half", out1_clk, 0);
            #2;
            chk(out1_clk == 0, "R5 disabled fast output low half", out1_clk, 0);
            @(posedge clk); #1;
        end
    endtask

    task automatic test_fast_switch_point();
        logic exp [0:5] = '{1, 1, 0, 0, 1, 0};
        logic got [0:5];
        out1_en = 1'b1;
        out1_fast = 1'b0;
        cycles(4);
        while (out1_clk != 1'b1) cycles(1);
        out1_fast = 1'b1;
        got[0] = out1_clk; #2; got[1] = out1_clk;
        @(posedge clk); #1; got[2] = out1_clk; #2; got[3] = out1_clk;
        @(posedge clk); #1; got[4] = out1_clk; #2; got[5] = out1_clk;
        for (int i = 0; i < 6; i++)
            chk(got[i] == exp[i], "R8 fast setting applied after low phase", got[i], exp[i]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        #1;
        test_reset();
        test_ratio(2'b01, 6, 6, 3);
        test_ratio(2'b10, 12, 12, 6);
        test_ratio(2'b11, 10, 10, 5);
        test_ratio(2'b00, 8, 7, 4);
        test_slow_disable();
        test_slow_switching();
        test_ratio(2'b00, 8, 7, 4);
        test_fast_modes();
        test_fast_switch_point();
        finish_run();
    end

endmodule